// File: doc/BRIEF.md
# Cascadable Dual PWM Generator

The block produces two pulse-width-modulated outputs from two 8-bit counter channels. Each channel has its own period value and its own duty value. The two channels can also be joined into one 16-bit channel that drives the first output.

All channels advance on a common count tick. Software selects the source of that tick: either a prescaler tick from a time base, or the overflow pulse of a separate 8-bit reload timer. In 16-bit operation, a fine mode can be switched on. It splits a 65536-count frame into 256 sub-cycles of 256 counts. The extra high counts are spread evenly across the sub-cycles, so the output ripples less when it is low-pass filtered into an analog level.

Software sets everything up through a simple write port. Period and duty values are held in shadow registers. They move into the running channel only at a period boundary.

Top module: `cascade_pwm`

## Requirements
- R1: After reset, both outputs are low, all registers are zero and both channels are stopped.
- R2: In 8-bit operation, a running channel counts 0, 1, ..., period on successive ticks and then returns to 0. Its output is high while the count is below the duty value. On the first cycle after the run bit is set, the output reflects count 0.
- R3: A duty of zero gives a constant low output. A duty greater than the period gives a constant high output. This holds in both 8-bit and 16-bit operation.
- R4: Period and duty writes go to shadow registers and reach the running channel at the next period boundary. A write in the same cycle as a boundary reaches the channel at the following boundary.
- R5: Control bit 3 selects the count tick: 0 selects the prescaler tick, 1 selects the reload-timer overflow. Pulses on the unselected input do not advance any counter.
- R6: Channel 1 has its own run bit (control bit 1) and drives the second output, independently of channel 0.
- R7: Control bit 2 joins the channels into one 16-bit channel. Channel 1 registers form the upper byte and channel 0 registers form the lower byte. The run bit of channel 0 controls this channel, its output appears on the first output, and the second output stays low.
- R8: Control bit 4, together with bit 2, selects fine mode. The frame is always 65536 counts and the period registers are ignored. In sub-cycle s (the upper count byte), the output is high for D_hi counts, plus one more count when the bit-reversed s is below D_lo. The frame therefore holds exactly D_hi*256 + D_lo high counts.
- R9: While a channel's run bit is clear, its counter stays at zero, its output is low, and its active values follow the shadow registers.
- R10: A control write that changes bit 2 or bit 4 zeroes both counters and loads the shadow values at once. A control write that changes only run or source bits does not disturb the counters.
- R11: Write addresses: 0 is the control register (bit 0 runs channel 0), 1 is the channel 0 period, 2 is the channel 0 duty, 3 is the channel 1 period and 4 is the channel 1 duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prescTick | input | 1 | Time-base prescaler tick, one-cycle pulse |
| reloadOvf | input | 1 | Reload-timer overflow pulse |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| pwmOut0 | output | 1 | Channel 0 output, or the 16-bit output |
| pwmOut1 | output | 1 | Channel 1 output, low in 16-bit operation |

## Verification
A duty write can land in the very cycle in which a tick ends a period. In that cycle the shadow register takes the new value while the active duty reloads from the shadow. The bench provokes this by reading the known count phase off the outputs and timing a duty write to the cycle in which the count equals the period. It then checks that the next full period still follows the old duty and that the new duty appears one period later. A second overlap, a mode change during a running count, is judged by the restart pattern that follows it on the output.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // strobes from the control side to the counting datapath
  typedef struct packed {
    logic tick;     // selected count tick, this cycle
    logic run0;     // channel 0 (or joined channel) running
    logic run1;     // channel 1 running
    logic cascade;  // channels joined into one wide channel
    logic fine;     // ripple-reduced mode, only with cascade
    logic restart;  // mode bits change on this edge
  } pwmStrb_t;

  localparam int CTRL_RUN0 = 0;
  localparam int CTRL_RUN1 = 1;
  localparam int CTRL_CAS  = 2;
  localparam int CTRL_SRC  = 3;
  localparam int CTRL_FINE = 4;
  localparam int CTRL_W    = 5;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       prescTick,
  input  logic                       reloadOvf,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [CNT_W-1:0]           wrData,
  output pwmStrb_t                   strb,
  output logic [1:0][CNT_W-1:0]      shPer,
  output logic [1:0][CNT_W-1:0]      shDuty
);
  localparam int NUM_CH = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;

  logic [CTRL_W-1:0] ctrlQ;
  logic ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= wrData[CTRL_W-1:0];
  end

  // per-channel shadow registers, addresses 1+2i (period) and 2+2i (duty)
  for (genvar g = 0; g < NUM_CH; g++) begin : gShadow
    localparam logic [ADDR_W-1:0] ADDR_PER  = ADDR_W'(1 + 2 * g);
    localparam logic [ADDR_W-1:0] ADDR_DUTY = ADDR_W'(2 + 2 * g);
    logic [CNT_W-1:0] perQ, dutyQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        perQ  <= '0;
        dutyQ <= '0;
      end else if (wrEn) begin
        if (wrAddr == ADDR_PER)  perQ  <= wrData;
        if (wrAddr == ADDR_DUTY) dutyQ <= wrData;
      end
    end
    assign shPer[g]  = perQ;
    assign shDuty[g] = dutyQ;
  end

  always_comb begin
    strb.tick    = ctrlQ[CTRL_SRC] ? reloadOvf : prescTick;
    strb.run0    = ctrlQ[CTRL_RUN0];
    strb.run1    = ctrlQ[CTRL_RUN1];
    strb.cascade = ctrlQ[CTRL_CAS];
    strb.fine    = ctrlQ[CTRL_FINE] & ctrlQ[CTRL_CAS];
    strb.restart = ctrlWr && ((wrData[CTRL_CAS]  != ctrlQ[CTRL_CAS]) ||
                              (wrData[CTRL_FINE] != ctrlQ[CTRL_FINE]));
  end

  // R11
  per_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(1)) |=> (shPer[0] == $past(wrData)));

  // R11
  duty_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(4)) |=> (shDuty[1] == $past(wrData)));
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pwmStrb_t              strb,
  input  logic [1:0][CNT_W-1:0] shPer,
  input  logic [1:0][CNT_W-1:0] shDuty,
  output logic                  out0,
  output logic                  out1
);
  localparam int NUM_CH = 2;
  localparam int WIDE_W = NUM_CH * CNT_W;

  logic [1:0][CNT_W-1:0] cnt, actPer, actDuty;
  logic [1:0] run, chEnd, narrowOut;
  logic [WIDE_W-1:0] wide, widePer, wideDuty, wideNext;
  logic [CNT_W-1:0] subRev;
  logic wideEnd, fineOut, wideOut;

  assign run[0]   = strb.run0;
  assign run[1]   = strb.cascade ? strb.run0 : strb.run1;
  assign wide     = cnt;
  assign widePer  = actPer;
  assign wideDuty = actDuty;
  assign wideNext = wide + 1'b1;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    assign chEnd[g]     = (cnt[g] == actPer[g]);
    assign narrowOut[g] = run[g] && (cnt[g] < actDuty[g]);
  end

  // sub-cycle index, bit-reversed, spreads the extra counts evenly
  for (genvar b = 0; b < CNT_W; b++) begin : gRev
    assign subRev[b] = cnt[1][CNT_W-1-b];
  end

  assign wideEnd = strb.fine ? (&wide) : (wide == widePer);
  assign fineOut = (cnt[0] < actDuty[1]) ||
                   ((cnt[0] == actDuty[1]) && (subRev < actDuty[0]));
  assign wideOut = strb.run0 && (strb.fine ? fineOut : (wide < wideDuty));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      actPer  <= '0;
      actDuty <= '0;
    end else if (strb.restart) begin
      cnt     <= '0;
      actPer  <= shPer;
      actDuty <= shDuty;
    end else if (strb.cascade) begin
      if (!strb.run0 || (strb.tick && wideEnd)) begin
        cnt     <= '0;
        actPer  <= shPer;
        actDuty <= shDuty;
      end else if (strb.tick) begin
        cnt <= wideNext;
      end
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (!run[i] || (strb.tick && chEnd[i])) begin
          cnt[i]     <= '0;
          actPer[i]  <= shPer[i];
          actDuty[i] <= shDuty[i];
        end else if (strb.tick) begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  end

  assign out0 = strb.cascade ? wideOut : narrowOut[0];
  assign out1 = !strb.cascade && narrowOut[1];

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cascade && strb.run0) |-> (cnt[0] <= actPer[0]));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run0 && !strb.cascade && !strb.tick && !strb.restart) |=> $stable(cnt[0]));

  // R3
  duty_zero_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cascade && actDuty[0] == '0) |-> !out0);

  // R7
  wide_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cascade && strb.run0 && strb.tick && wideEnd && !strb.restart) |=> (cnt == '0));

  // R9
  stopped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run1 && !strb.cascade) |=> (cnt[1] == '0));
endmodule

// File: rtl/cascade_pwm.sv
module cascade_pwm
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prescTick,
  input  logic              reloadOvf,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              pwmOut0,
  output logic              pwmOut1
);
  pwmStrb_t strb;
  logic [1:0][CNT_W-1:0] shPer, shDuty;

  pwm_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .prescTick(prescTick), .reloadOvf(reloadOvf),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .shPer(shPer), .shDuty(shDuty)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rstN(rstN), .strb(strb), .shPer(shPer), .shDuty(shDuty),
    .out0(pwmOut0), .out1(pwmOut1)
  );
endmodule

// File: tb/cascade_pwm_tb.sv
`timescale 1ns/1ps
module cascade_pwm_tb;
  logic clk = 1'b0;
  logic rstN, prescTick, reloadOvf, wrEn;
  logic [2:0] wrAddr;
  logic [7:0] wrData;
  logic pwmOut0, pwmOut1;
  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_pwm u_dut (
    .clk(clk), .rstN(rstN), .prescTick(prescTick), .reloadOvf(reloadOvf),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut0(pwmOut0), .pwmOut1(pwmOut1)
  );

  // {period, duty, expected high counts per period}
  localparam logic [23:0] VEC [8] = '{
    {8'd9,   8'd3,   8'd3},
    {8'd9,   8'd0,   8'd0},
    {8'd4,   8'd4,   8'd4},
    {8'd9,   8'd10,  8'd10},
    {8'd9,   8'd200, 8'd10},
    {8'd255, 8'd128, 8'd128},
    {8'd0,   8'd1,   8'd1},
    {8'd0,   8'd0,   8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic doWrite(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int rev8(input int s);
    int r = 0;
    for (int b = 0; b < 8; b++) if (s[b]) r |= (1 << (7 - b));
    return r;
  endfunction

  initial begin
    #750000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    int hi, lo1, bad;
    int subHi [256];
    logic [7:0] per, duty, exp;
    bit pat0 [8];
    bit pat1 [8];
    rstN = 1'b0; prescTick = 1'b0; reloadOvf = 1'b0;
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    chk(pwmOut0 == 1'b0 && pwmOut1 == 1'b0, "R1 outputs in reset", {pwmOut1, pwmOut0}, 0);
    rstN = 1'b1;
    prescTick = 1'b1;
    repeat (4) @(negedge clk);
    chk(pwmOut0 == 1'b0 && pwmOut1 == 1'b0, "R1 stopped after reset", {pwmOut1, pwmOut0}, 0);

    // R9: stopped channel stays low even with a large duty
    doWrite(3'd2, 8'hFF);
    repeat (3) @(negedge clk);
    chk(pwmOut0 == 1'b0, "R9 stopped output low", pwmOut0, 0);

    // R2 / R3 vector table
    foreach (VEC[v]) begin
      {per, duty, exp} = VEC[v];
      doWrite(3'd0, 8'h00);
      doWrite(3'd1, per);
      doWrite(3'd2, duty);
      doWrite(3'd0, 8'h01);
      hi = 0;
      for (int k = 0; k <= int'(per); k++) begin
        hi += int'(pwmOut0);
        @(negedge clk);
      end
      chk(hi == int'(exp), "R2 R3 high count per period", hi, int'(exp));
    end

    // R2 exact waveform, period 3 duty 2
    pat0 = '{1, 1, 0, 0, 1, 1, 0, 0};
    doWrite(3'd0, 8'h00);
    doWrite(3'd1, 8'd3);
    doWrite(3'd2, 8'd2);
    doWrite(3'd0, 8'h01);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      chk(pwmOut0 == pat0[k], "R2 waveform", pwmOut0, pat0[k]);
    end
    // R4: count is 3 here; write duty 4 in the boundary cycle
    pat1 = '{1, 1, 0, 0, 1, 1, 1, 1};
    doWrite(3'd2, 8'd4);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      chk(pwmOut0 == pat1[k], "R4 boundary write deferred", pwmOut0, pat1[k]);
    end

    // R5 tick source
    doWrite(3'd0, 8'h00);
    doWrite(3'd2, 8'd2);
    prescTick = 1'b0; reloadOvf = 1'b1;
    doWrite(3'd0, 8'h01);
    hi = 0;
    for (int k = 0; k < 6; k++) begin
      hi += int'(pwmOut0);
      @(negedge clk);
    end
    chk(hi == 6, "R5 unselected overflow ignored", hi, 6);
    doWrite(3'd0, 8'h09);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      chk(pwmOut0 == pat0[k], "R5 overflow source counts", pwmOut0, pat0[k]);
    end
    reloadOvf = 1'b0; prescTick = 1'b1;
    hi = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      hi += int'(pwmOut0);
    end
    chk(hi == 0, "R5 unselected prescaler ignored", hi, 0);

    // R6 channel 1 alone
    reloadOvf = 1'b0; prescTick = 1'b1;
    doWrite(3'd0, 8'h00);
    doWrite(3'd3, 8'd1);
    doWrite(3'd4, 8'd1);
    doWrite(3'd0, 8'h02);
    hi = 0;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      chk(pwmOut1 == ((k % 2) == 0), "R6 channel 1 waveform", pwmOut1, (k % 2) == 0);
      hi += int'(pwmOut0);
    end
    chk(hi == 0, "R6 channel 0 unaffected", hi, 0);

    // R7 16-bit: period 0x0102, duty 0x0101
    doWrite(3'd0, 8'h00);
    doWrite(3'd1, 8'h02);
    doWrite(3'd3, 8'h01);
    doWrite(3'd2, 8'h01);
    doWrite(3'd4, 8'h01);
    doWrite(3'd0, 8'h05);
    hi = 0; lo1 = 0;
    for (int k = 0; k < 259; k++) begin
      hi += int'(pwmOut0);
      lo1 += int'(pwmOut1);
      @(negedge clk);
    end
    chk(hi == 257, "R7 wide high count", hi, 257);
    chk(lo1 == 0, "R7 second output low", lo1, 0);
    // R3 in 16-bit: duty 0x0201 > period
    doWrite(3'd4, 8'h02);
    repeat (300) @(negedge clk);
    hi = 0;
    for (int k = 0; k < 259; k++) begin
      hi += int'(pwmOut0);
      @(negedge clk);
    end
    chk(hi == 259, "R3 wide duty above period", hi, 259);

    // R10 leaving cascade restarts: period 2 duty 1
    doWrite(3'd0, 8'h01);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) @(negedge clk);
      chk(pwmOut0 == ((k % 3) == 0), "R10 restart on mode change", pwmOut0, (k % 3) == 0);
    end

    // R8 fine mode, D_hi 0x40 D_lo 3
    doWrite(3'd0, 8'h00);
    doWrite(3'd2, 8'h03);
    doWrite(3'd4, 8'h40);
    doWrite(3'd0, 8'h15);
    foreach (subHi[s]) subHi[s] = 0;
    hi = 0; lo1 = 0;
    for (int k = 0; k < 65536; k++) begin
      subHi[k >> 8] += int'(pwmOut0);
      hi += int'(pwmOut0);
      lo1 += int'(pwmOut1);
      @(negedge clk);
    end
    chk(hi == 16387, "R8 fine frame total", hi, 16387);
    bad = 0;
    for (int s = 0; s < 256; s++)
      if (subHi[s] != 64 + ((rev8(s) < 3) ? 1 : 0)) bad++;
    chk(bad == 0, "R8 extra counts spread", bad, 0);
    chk(lo1 == 0, "R7 second output low in fine mode", lo1, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule